// File: doc/BRIEF.md
# Endian-Correcting Bus Router

This block sits between a big-endian 32-bit processor and a little-endian, byte-addressed backing store. It accepts one read or write per cycle over a valid/ready request interface. Each request carries a size: byte, halfword or word.

For each request the block does two things:

- It corrects the low address bits for the size, so that narrow accesses reach the right byte lanes of the store.
- It decodes the address into one of several targets: a local RAM port, a secondary memory window, a free-running cycle timer, a constant returned for unmapped reads, or an output port.

Both memory ports are synchronous, and read data appears one cycle after the strobe. The router returns that data to the requester in the same cycle, marked by a response valid.

Writes to the output port load a data register and raise a command code. The requester is then held off, with ready low, until the consumer on the far side clears the command back to zero.

Top module: `endian_bus_router`

## Requirements
- R1: A byte access (size code 00) below 0xFFFF reaches the local RAM port with address bits [1:0] inverted (XOR 11) and all other bits unchanged.
- R2: A halfword access (size code 01) below 0xFFFF reaches the local RAM port with address bit 1 inverted (XOR 10). A word access (size code 10) below 0xFFFF reaches it with the address unchanged.
- R3: A word access with an address below 0xFFFF strobes only the local RAM port. For a read, the RAM data returned in the next cycle appears on the response.
- R4: A word access from 0xFFFF up to and including 0x1FFFF strobes only the window port, at the address minus 0xFFFF. For a read, the window data appears on the response in the next cycle.
- R5: A word read at 0x80000100 returns a cycle counter that increments by one every clock. Two such reads return values that differ by the number of cycles between their acceptances.
- R6: Any other word read above 0x1FFFF strobes no memory port and returns 0x00000100.
- R7: A word write above 0x1FFFF strobes no memory port. From the next cycle it holds the write data on the output data register and command code 0x01 on the command register.
- R8: While the command register is non-zero, ready is low, no request is accepted, and the command and data stay unchanged. A clear pulse returns the command to zero, and ready rises in the following cycle.
- R9: A byte or halfword access at or above 0xFFFF, or any access with the reserved size code 11, strobes no port and raises no command. Such a read returns zero.
- R10: While reset is asserted, ready is high, the response valid is low, and the command and output data registers are zero.
- R11: The response valid is high exactly in the cycle after an accepted read. An accepted write produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_addr | input | 32 | Byte address as seen by the processor |
| req_wdata | input | 32 | Write data, right-aligned for narrow sizes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| lram_en | output | 1 | Local RAM strobe |
| lram_we | output | 1 | Local RAM write enable |
| lram_size | output | 2 | Access size passed to local RAM |
| lram_addr | output | 32 | Swizzled local RAM address |
| lram_wdata | output | 32 | Local RAM write data |
| lram_rdata | input | 32 | Local RAM read data, one cycle after the strobe |
| win_en | output | 1 | Window strobe |
| win_we | output | 1 | Window write enable |
| win_addr | output | 32 | Window offset address |
| win_wdata | output | 32 | Window write data |
| win_rdata | input | 32 | Window read data, one cycle after the strobe |
| out_cmd | output | 8 | Output command register |
| out_data | output | 32 | Output data register |
| out_clear | input | 1 | Consumer clears the command register |

## Verification
On every cycle, the checker tests four relations:

- The two memory strobes are never high together.
- Narrow accesses carry the inverted low address bits.
- A window strobe only follows a word request inside the window range.
- A response only follows an accepted read.

It also checks that a pending command holds its value, and keeps ready low, until it is cleared. The reset values, the response data chosen for each target, the timer difference between two reads, the 0x100 and zero fill values, and the fact that a request offered during a stall is accepted only after the clear are shown by the bench's scenarios.

// File: rtl/ebr_pkg.sv
// Shared types for the endian-correcting bus router.
package ebr_pkg;
    // Request size codes as driven on req_size.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    // Destination chosen by the address decoder.
    typedef enum logic [2:0] {
        TG_NONE   = 3'd0,
        TG_LOCAL  = 3'd1,
        TG_WINDOW = 3'd2,
        TG_TIMER  = 3'd3,
        TG_CONST  = 3'd4,
        TG_OUT    = 3'd5
    } target_e;
endpackage

// File: rtl/ebr_addr_swizzle.sv
// Address endianness correction.
// Inverts the low address bits according to the access size, so that a
// big-endian requester reaches the correct lanes of a little-endian store.
// Assumes byte addressing. Word and reserved sizes pass unchanged.
module ebr_addr_swizzle
    import ebr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  acc_size_e           size,
    input  logic [ADDR_W-1:0]   addr_in,
    output logic [ADDR_W-1:0]   addr_out
);
    localparam logic [1:0] BYTE_FLIP = 2'b11;
    localparam logic [1:0] HALF_FLIP = 2'b10;

    // Pick the lane-flip mask for this size and apply it to the low bits.
    always_comb begin
        addr_out = addr_in;
        case (size)
            SZ_BYTE: addr_out[1:0] = addr_in[1:0] ^ BYTE_FLIP;
            SZ_HALF: addr_out[1:0] = addr_in[1:0] ^ HALF_FLIP;
            default: addr_out      = addr_in;
        endcase
    end
endmodule

// File: rtl/ebr_region_decode.sv
// Address decoder.
// Maps a request to one destination. Anything below LOCAL_TOP goes to
// local RAM. Words from LOCAL_TOP to WIN_TOP go to the window, rebased to
// LOCAL_TOP. Words above WIN_TOP are I/O: writes go to the output port,
// reads go to the timer or the constant.
// Assumes LOCAL_TOP <= WIN_TOP < TIMER_ADDR.
module ebr_region_decode
    import ebr_pkg::*;
#(
    parameter int                 ADDR_W     = 32,
    parameter logic [ADDR_W-1:0]  LOCAL_TOP  = 32'h0000_FFFF,
    parameter logic [ADDR_W-1:0]  WIN_TOP    = 32'h0001_FFFF,
    parameter logic [ADDR_W-1:0]  TIMER_ADDR = 32'h8000_0100
) (
    input  acc_size_e           size,
    input  logic                is_write,
    input  logic [ADDR_W-1:0]   addr,
    output target_e             target,
    output logic [ADDR_W-1:0]   win_offset
);
    // Rebase window addresses so the window store starts at zero.
    always_comb win_offset = addr - LOCAL_TOP;

    // Choose the destination from the address region, the size and the direction.
    always_comb begin
        if (addr < LOCAL_TOP) begin
            target = (size == SZ_RSVD) ? TG_NONE : TG_LOCAL;
        end else if (size != SZ_WORD) begin
            target = TG_NONE;
        end else if (addr <= WIN_TOP) begin
            target = TG_WINDOW;
        end else if (is_write) begin
            target = TG_OUT;
        end else if (addr == TIMER_ADDR) begin
            target = TG_TIMER;
        end else begin
            target = TG_CONST;
        end
    end
endmodule

// File: rtl/ebr_out_port.sv
// Output command register pair.
// A launch loads the data register and writes the command code. The
// consumer clears the command through a clear pulse. Busy is high while
// the command is non-zero. Assumes no launch while busy, since the top
// withholds ready in that state.
module ebr_out_port #(
    parameter int                DATA_W   = 32,
    parameter int                CMD_W    = 8,
    parameter logic [CMD_W-1:0]  OUT_CODE = 8'h01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [DATA_W-1:0]   launch_data,
    input  logic                clear,
    output logic [CMD_W-1:0]    cmd,
    output logic [DATA_W-1:0]   data,
    output logic                busy
);
    // Load on launch, drop the command when the consumer clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= '0;
            data <= '0;
        end else if (launch) begin
            cmd  <= OUT_CODE;
            data <= launch_data;
        end else if (clear) begin
            cmd  <= '0;
        end
    end

    // Requester is held off while a command is pending.
    always_comb busy = |cmd;
endmodule

// File: rtl/ebr_cycle_timer.sv
// Free-running cycle counter: zero in reset, plus one every clock after.
module ebr_cycle_timer #(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CNT_W-1:0]  count
);
    // Count every clock, wrapping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/endian_bus_router.sv
// Endian-correcting bus router (top).
// Accepts one request per cycle when ready and drives at most one memory
// strobe in the same cycle. It returns read data one cycle later. The memory
// ports must deliver read data one cycle after their strobe. Timer and
// constant reads are answered from internal state with the same latency.
module endian_bus_router
    import ebr_pkg::*;
#(
    parameter int                 ADDR_W       = 32,
    parameter int                 DATA_W       = 32,
    parameter int                 CMD_W        = 8,
    parameter logic [ADDR_W-1:0]  LOCAL_TOP    = 32'h0000_FFFF,
    parameter logic [ADDR_W-1:0]  WIN_TOP      = 32'h0001_FFFF,
    parameter logic [ADDR_W-1:0]  TIMER_ADDR   = 32'h8000_0100,
    parameter logic [DATA_W-1:0]  UNMAPPED_VAL = 32'h0000_0100,
    parameter logic [CMD_W-1:0]   OUT_CODE     = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               lram_en,
    output logic               lram_we,
    output logic [1:0]         lram_size,
    output logic [ADDR_W-1:0]  lram_addr,
    output logic [DATA_W-1:0]  lram_wdata,
    input  logic [DATA_W-1:0]  lram_rdata,
    output logic               win_en,
    output logic               win_we,
    output logic [ADDR_W-1:0]  win_addr,
    output logic [DATA_W-1:0]  win_wdata,
    input  logic [DATA_W-1:0]  win_rdata,
    output logic [CMD_W-1:0]   out_cmd,
    output logic [DATA_W-1:0]  out_data,
    input  logic               out_clear
);
    acc_size_e          size;
    target_e            target;
    target_e            sel_q;
    logic [ADDR_W-1:0]  swz_addr;
    logic [ADDR_W-1:0]  win_offset;
    logic [DATA_W-1:0]  tick;
    logic [DATA_W-1:0]  tick_q;
    logic               accept;
    logic               out_busy;
    logic               rsp_q;

    // Interpret the raw size code.
    always_comb size = acc_size_e'(req_size);

    ebr_addr_swizzle #(.ADDR_W(ADDR_W)) i_swizzle (
        .size     (size),
        .addr_in  (req_addr),
        .addr_out (swz_addr)
    );

    ebr_region_decode #(
        .ADDR_W     (ADDR_W),
        .LOCAL_TOP  (LOCAL_TOP),
        .WIN_TOP    (WIN_TOP),
        .TIMER_ADDR (TIMER_ADDR)
    ) i_decode (
        .size       (size),
        .is_write   (req_write),
        .addr       (req_addr),
        .target     (target),
        .win_offset (win_offset)
    );

    ebr_cycle_timer #(.CNT_W(DATA_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .count (tick)
    );

    ebr_out_port #(
        .DATA_W   (DATA_W),
        .CMD_W    (CMD_W),
        .OUT_CODE (OUT_CODE)
    ) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (accept && target == TG_OUT),
        .launch_data (req_wdata),
        .clear       (out_clear),
        .cmd         (out_cmd),
        .data        (out_data),
        .busy        (out_busy)
    );

    // Handshake: a pending output command stalls the requester.
    always_comb begin
        req_ready = !out_busy;
        accept    = req_valid && req_ready;
    end

    // Local RAM port: strobed only for accepted local requests.
    always_comb begin
        lram_en    = accept && target == TG_LOCAL;
        lram_we    = req_write;
        lram_size  = req_size;
        lram_addr  = swz_addr;
        lram_wdata = req_wdata;
    end

    // Window port: strobed only for accepted window words.
    always_comb begin
        win_en    = accept && target == TG_WINDOW;
        win_we    = req_write;
        win_addr  = win_offset;
        win_wdata = req_wdata;
    end

    // Remember which source answers an accepted read, and snapshot the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q  <= 1'b0;
            sel_q  <= TG_NONE;
            tick_q <= '0;
        end else begin
            rsp_q <= accept && !req_write;
            if (accept && !req_write) sel_q <= target;
            if (accept && target == TG_TIMER) tick_q <= tick;
        end
    end

    // Steer the selected source onto the response.
    always_comb begin
        rsp_valid = rsp_q;
        case (sel_q)
            TG_LOCAL:  rsp_rdata = lram_rdata;
            TG_WINDOW: rsp_rdata = win_rdata;
            TG_TIMER:  rsp_rdata = tick_q;
            TG_CONST:  rsp_rdata = UNMAPPED_VAL;
            default:   rsp_rdata = '0;
        endcase
    end
endmodule

// File: rtl/endian_bus_router_chk.sv
// Property checker for endian_bus_router. It observes ports only and is
// attached with the bind at the end of this file.
module endian_bus_router_chk #(
    parameter int                 ADDR_W    = 32,
    parameter int                 DATA_W    = 32,
    parameter int                 CMD_W     = 8,
    parameter logic [ADDR_W-1:0]  LOCAL_TOP = 32'h0000_FFFF,
    parameter logic [ADDR_W-1:0]  WIN_TOP   = 32'h0001_FFFF
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               req_write,
    input logic [1:0]         req_size,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_valid,
    input logic               lram_en,
    input logic [ADDR_W-1:0]  lram_addr,
    input logic               win_en,
    input logic [CMD_W-1:0]   out_cmd,
    input logic [DATA_W-1:0]  out_data,
    input logic               out_clear
);
    p_byte_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lram_en && req_size == 2'b00) |-> (lram_addr == (req_addr ^ 32'h3)));

    p_half_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lram_en && req_size == 2'b01) |-> (lram_addr == (req_addr ^ 32'h2)));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(lram_en && win_en));

    p_window_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_en |-> (req_size == 2'b10 && req_addr >= LOCAL_TOP && req_addr <= WIN_TOP));

    p_cmd_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_cmd != '0) |->
            $past(req_valid && req_ready && req_write && req_size == 2'b10 && req_addr > WIN_TOP));

    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd != '0) |-> !req_ready);

    p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cmd != '0 && !out_clear) |=> ($stable(out_cmd) && $stable(out_data)));

    p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && req_ready && !req_write));
endmodule

bind endian_bus_router endian_bus_router_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_W     (CMD_W),
    .LOCAL_TOP (LOCAL_TOP),
    .WIN_TOP   (WIN_TOP)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_size  (req_size),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .lram_en   (lram_en),
    .lram_addr (lram_addr),
    .win_en    (win_en),
    .out_cmd   (out_cmd),
    .out_data  (out_data),
    .out_clear (out_clear)
);

// File: tb/test_endian_bus_router.sv
`timescale 1ns/1ps
module test_endian_bus_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        lram_en, lram_we;
    logic [1:0]  lram_size;
    logic [31:0] lram_addr, lram_wdata, lram_rdata;
    logic        win_en, win_we;
    logic [31:0] win_addr, win_wdata, win_rdata;
    logic [7:0]  out_cmd;
    logic [31:0] out_data;
    logic        out_clear = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int tb_cyc = 0;
    logic [31:0] lat_l = '0;
    logic [31:0] lat_w = '0;

    localparam logic [31:0] LTAG = 32'hC0DE_0000;
    localparam logic [31:0] WTAG = 32'hBEEF_0000;

    endian_bus_router i_endian_bus_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lram_en(lram_en), .lram_we(lram_we), .lram_size(lram_size),
        .lram_addr(lram_addr), .lram_wdata(lram_wdata), .lram_rdata(lram_rdata),
        .win_en(win_en), .win_we(win_we), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_rdata(win_rdata),
        .out_cmd(out_cmd), .out_data(out_data), .out_clear(out_clear)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) tb_cyc <= tb_cyc + 1;

    // Memory models: read data is a tagged copy of the last strobed address.
    always @(posedge clk) begin
        if (lram_en) lat_l <= lram_addr;
        if (win_en)  lat_w <= win_addr;
    end
    assign lram_rdata = lat_l ^ LTAG;
    assign win_rdata  = lat_w ^ WTAG;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // tgt: 0 none, 1 local, 2 window, 3 constant
    typedef struct packed {
        logic        we;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  tgt;
        logic [31:0] taddr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b00, 32'h0000_0010, 32'h0,         2'd1, 32'h0000_0013, 4'd1}, // R1
        '{1'b0, 2'b00, 32'h0000_0013, 32'h0,         2'd1, 32'h0000_0010, 4'd1}, // R1
        '{1'b0, 2'b01, 32'h0000_0020, 32'h0,         2'd1, 32'h0000_0022, 4'd2}, // R2
        '{1'b0, 2'b01, 32'h0000_0023, 32'h0,         2'd1, 32'h0000_0021, 4'd2}, // R2
        '{1'b0, 2'b10, 32'h0000_0040, 32'h0,         2'd1, 32'h0000_0040, 4'd2}, // R2 word unchanged
        '{1'b0, 2'b10, 32'h0000_FFFE, 32'h0,         2'd1, 32'h0000_FFFE, 4'd3}, // R3 top of local
        '{1'b0, 2'b10, 32'h0000_FFFF, 32'h0,         2'd2, 32'h0000_0000, 4'd4}, // R4 window base
        '{1'b0, 2'b10, 32'h0001_FFFF, 32'h0,         2'd2, 32'h0001_0000, 4'd4}, // R4 window top
        '{1'b0, 2'b10, 32'h0002_0000, 32'h0,         2'd3, 32'h0,         4'd6}, // R6
        '{1'b0, 2'b10, 32'h8000_0104, 32'h0,         2'd3, 32'h0,         4'd6}, // R6 next to timer
        '{1'b0, 2'b00, 32'h0002_0000, 32'h0,         2'd0, 32'h0,         4'd9}, // R9
        '{1'b0, 2'b01, 32'h0000_FFFF, 32'h0,         2'd0, 32'h0,         4'd9}, // R9
        '{1'b1, 2'b00, 32'h0000_0031, 32'h0000_00AB, 2'd1, 32'h0000_0032, 4'd1}, // R1 write
        '{1'b1, 2'b10, 32'h0001_0100, 32'h1234_5678, 2'd2, 32'h0000_0101, 4'd4}, // R4 write
        '{1'b1, 2'b00, 32'h0003_0000, 32'h0000_0055, 2'd0, 32'h0,         4'd9}, // R9 write
        '{1'b1, 2'b01, 32'h0001_2345, 32'h0000_6666, 2'd0, 32'h0,         4'd9}, // R9 write
        '{1'b0, 2'b11, 32'h0000_0040, 32'h0,         2'd0, 32'h0,         4'd9}  // R9 reserved size
    };

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] t1, t2;
        int c1, c2;
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "ready", {31'b0, req_ready}, 32'd1);
        chk("R10", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R10", "out_cmd", {24'b0, out_cmd}, 32'd0);
        chk("R10", "out_data", out_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one request per vector (R1 R2 R3 R4 R6 R9 R11)
        for (int i = 0; i < NV; i++) begin
            string rq;
            logic [31:0] exp_rd;
            rq = $sformatf("R%0d", VECS[i].rq);
            req_valid = 1'b1;
            req_write = VECS[i].we;
            req_size  = VECS[i].size;
            req_addr  = VECS[i].addr;
            req_wdata = VECS[i].wdata;
            #1;
            chk(rq, "lram_en", {31'b0, lram_en}, {31'b0, VECS[i].tgt == 2'd1});
            chk(rq, "win_en",  {31'b0, win_en},  {31'b0, VECS[i].tgt == 2'd2});
            if (VECS[i].tgt == 2'd1) begin
                chk(rq, "lram_addr", lram_addr, VECS[i].taddr);
                chk(rq, "lram_we", {31'b0, lram_we}, {31'b0, VECS[i].we});
                if (VECS[i].we) chk(rq, "lram_wdata", lram_wdata, VECS[i].wdata);
            end
            if (VECS[i].tgt == 2'd2) begin
                chk(rq, "win_addr", win_addr, VECS[i].taddr);
                chk(rq, "win_we", {31'b0, win_we}, {31'b0, VECS[i].we});
                if (VECS[i].we) chk(rq, "win_wdata", win_wdata, VECS[i].wdata);
            end
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            case (VECS[i].tgt)
                2'd1:    exp_rd = VECS[i].taddr ^ LTAG;
                2'd2:    exp_rd = VECS[i].taddr ^ WTAG;
                2'd3:    exp_rd = 32'h0000_0100;
                default: exp_rd = 32'h0;
            endcase
            chk(rq, "out_cmd idle", {24'b0, out_cmd}, 32'd0);
            chk("R11", "rsp_valid", {31'b0, rsp_valid}, {31'b0, !VECS[i].we});
            if (!VECS[i].we) chk(rq, "rsp_rdata", rsp_rdata, exp_rd);
        end

        // R5: timer difference equals the cycles between acceptances
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'b10; req_addr = 32'h8000_0100;
        c1 = tb_cyc;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        t1 = rsp_rdata;
        chk("R5", "timer rsp_valid", {31'b0, rsp_valid}, 32'd1);
        repeat (6) @(negedge clk);
        req_valid = 1'b1;
        c2 = tb_cyc;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        t2 = rsp_rdata;
        chk("R5", "timer delta", t2 - t1, 32'(c2 - c1));

        // R7 R8: output write, stall, clear
        req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
        req_addr = 32'h0003_0000; req_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R7", "no lram strobe", {31'b0, lram_en}, 32'd0);
        chk("R7", "no win strobe", {31'b0, win_en}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7", "out_cmd", {24'b0, out_cmd}, 32'h01);
        chk("R7", "out_data", out_data, 32'hDEAD_BEEF);
        chk("R8", "ready low", {31'b0, req_ready}, 32'd0);
        // Offer a read while stalled; it must not be taken.
        req_write = 1'b0; req_addr = 32'h0000_0040; req_wdata = 32'h0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R8", "no strobe while stalled", {31'b0, lram_en}, 32'd0);
            @(posedge clk); @(negedge clk);
            chk("R8", "cmd held", {24'b0, out_cmd}, 32'h01);
            chk("R8", "no rsp while stalled", {31'b0, rsp_valid}, 32'd0);
        end
        chk("R8", "data held", out_data, 32'hDEAD_BEEF);
        out_clear = 1'b1;
        @(posedge clk); @(negedge clk);
        out_clear = 1'b0;
        chk("R8", "cmd cleared", {24'b0, out_cmd}, 32'd0);
        chk("R8", "ready back", {31'b0, req_ready}, 32'd1);
        #1;
        chk("R8", "pending read taken", {31'b0, lram_en}, 32'd1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R11", "rsp after stall", {31'b0, rsp_valid}, 32'd1);
        chk("R3", "rdata after stall", rsp_rdata, 32'h40 ^ LTAG);

        // R7: a write to the timer address also goes to the output port
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h8000_0100; req_wdata = 32'h0BAD_F00D;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R7", "timer addr write cmd", {24'b0, out_cmd}, 32'h01);
        chk("R7", "timer addr write data", out_data, 32'h0BAD_F00D);
        chk("R11", "no rsp for write", {31'b0, rsp_valid}, 32'd0);
        out_clear = 1'b1;
        @(posedge clk); @(negedge clk);
        out_clear = 1'b0;
        chk("R8", "second clear", {24'b0, out_cmd}, 32'd0);

        finish_run();
    end
endmodule